// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block picks, every clock cycle, which of several hardware thread contexts a pipelined front end fetches or issues from. It produces a thread index that the surrounding pipeline uses to select that thread's program counter and register context. It also drives a valid flag, which is low when no thread can issue. A switch pulse tells the pipeline to flush the instructions of the thread it just left.

Two modes are supported. In fine-grained mode the choice rotates in round-robin order on every cycle and passes over threads that cannot issue. In coarse-grained mode the selector stays on one thread until that thread reports a costly stall, such as a second-level cache miss. It then moves to the next thread that can issue, and only then. Outputs are registered: the inputs seen at one clock edge determine the outputs that appear right after it.

Top module: `mt_thread_sel`

## Requirements
- R1: While rst_ni is low and directly after reset, tid_o is 0, valid_o is 0 and switch_o is 0. The mode register starts as fine-grained (mode_i 0 = fine, 1 = coarse).
- R2: In fine-grained mode, the search for the next thread starts at the thread after the one currently on tid_o and wraps around in increasing index order. The current thread itself is considered last.
- R3: A thread is eligible only when its ready_i bit is 1 and its stall_i bit is 0. Ineligible threads are skipped, and valid_o high always names a thread that was eligible at the deciding edge.
- R4: When no thread qualifies, valid_o is 0 and tid_o keeps its previous value.
- R5: In coarse-grained mode, while the current thread is ready and long_stall_i is low, tid_o does not change. A short stall (stall_i on the current thread) only drops valid_o.
- R6: In coarse-grained mode, long_stall_i moves tid_o to the next eligible thread other than the current one, in round-robin order. valid_o is 1 and switch_o is high for that one cycle.
- R7: In coarse-grained mode, if long_stall_i arrives and no other thread is eligible, tid_o stays, valid_o is 0 and switch_o stays low.
- R8: In coarse-grained mode, if the current thread's ready_i is low, the selector switches to the next eligible thread with a switch_o pulse, as in R6.
- R9: A change on mode_i takes effect only at a selection boundary. In fine mode every cycle is a boundary; in coarse mode only a cycle that switches threads is one.
- R10: switch_o is never high for a selection made in fine-grained mode, and whenever it is high tid_o differs from its previous value.
- R11: long_stall_i has no effect in fine-grained mode.
- R12: Outputs reflect the inputs sampled at the preceding rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Requested mode: 0 fine-grained, 1 coarse-grained |
| ready_i | input | NUM_THREADS | Thread has a live context able to issue |
| stall_i | input | NUM_THREADS | Thread is in a short stall |
| long_stall_i | input | 1 | Costly stall on the currently selected thread |
| tid_o | output | $clog2(NUM_THREADS) | Selected thread index |
| valid_o | output | 1 | Selected thread issues this cycle |
| switch_o | output | 1 | One-cycle pulse on a coarse-grained switch |

## Verification
The thread pointer is the only state the round-robin search depends on. If that pointer or the registered mode is corrupted, the fine-mode rotation order shows a wrong tid_o on the very next cycle. In coarse mode the same fault appears as a spurious or missing switch_o. A wrong eligibility mask is caught by valid_o asserting for a stalled or not-ready thread one cycle after the input edge. The bench compares every output against a behavioural model on every cycle, so any such divergence is flagged in the cycle it appears.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/mt_rr_picker.sv
module mt_rr_picker #(
  parameter int NUM   = 4,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]   req_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             incl_base_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // descending scan so the closest successor of base wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = base_i;
    for (int k = NUM; k >= 1; k--) begin
      int cand;
      cand = (int'(base_i) + k) % NUM;
      if (req_i[cand] && ((k < NUM) || incl_base_i)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/mt_mode_reg.sv
module mt_mode_reg
  import mt_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mode_i,
  input  logic      boundary_i,
  output sel_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_o <= MODE_FINE;
    else if (boundary_i) mode_o <= sel_mode_e'(mode_i);
  end

  // R9
  mode_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> $past(boundary_i));
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
  import mt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TidW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [NUM_THREADS-1:0] stall_i,
  input  logic                   long_stall_i,
  output logic [TidW-1:0]        tid_o,
  output logic                   valid_o,
  output logic                   switch_o
);
  localparam int NumPick = 2;  // 0: include current thread, 1: exclude it

  sel_mode_e              mode_q;
  logic [NUM_THREADS-1:0] elig;
  logic [NumPick-1:0]     pick_hit;
  logic [TidW-1:0]        pick_idx [NumPick];
  logic [TidW-1:0]        nxt_tid;
  logic                   nxt_valid, nxt_sw, boundary;

  assign elig = ready_i & ~stall_i;

  for (genvar g = 0; g < NumPick; g++) begin : g_pick
    mt_rr_picker #(.NUM(NUM_THREADS), .IDX_W(TidW)) u_pick (
      .req_i       (elig),
      .base_i      (tid_o),
      .incl_base_i (g == 0),
      .hit_o       (pick_hit[g]),
      .idx_o       (pick_idx[g])
    );
  end

  always_comb begin
    nxt_tid   = tid_o;
    nxt_valid = 1'b0;
    nxt_sw    = 1'b0;
    if (mode_q == MODE_FINE) begin
      nxt_valid = pick_hit[0];
      if (pick_hit[0]) nxt_tid = pick_idx[0];
    end else if (long_stall_i || !ready_i[tid_o]) begin
      if (pick_hit[1]) begin
        nxt_tid   = pick_idx[1];
        nxt_valid = 1'b1;
        nxt_sw    = 1'b1;
      end
    end else begin
      nxt_valid = elig[tid_o];
    end
  end

  assign boundary = (mode_q == MODE_FINE) || nxt_sw;

  mt_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .boundary_i (boundary),
    .mode_o     (mode_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tid_o    <= '0;
      valid_o  <= 1'b0;
      switch_o <= 1'b0;
    end else begin
      tid_o    <= nxt_tid;
      valid_o  <= nxt_valid;
      switch_o <= nxt_sw;
    end
  end

  // R3
  valid_is_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> |($past(elig) & (NUM_THREADS'(1) << tid_o)));
  // R4
  idle_holds_tid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(tid_o));
  // R10
  switch_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> (valid_o && (tid_o != $past(tid_o))));
  // R10
  switch_only_coarse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> ($past(mode_q) == MODE_COARSE));
  // R5
  coarse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mode_q) == MODE_COARSE) && !switch_o) |-> $stable(tid_o));
endmodule

// File: tb/mt_thread_sel_tb.sv
`timescale 1ns/1ps
module mt_thread_sel_tb;
  localparam int T = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic [T-1:0] ready_i = '0;
  logic [T-1:0] stall_i = '0;
  logic         long_stall_i = 1'b0;
  logic [1:0]   tid_o;
  logic         valid_o, switch_o;

  int checks = 0;
  int errors = 0;
  int m_tid = 0, m_valid = 0, m_sw = 0, m_mode = 0;

  always #2 clk_i = ~clk_i;

  mt_thread_sel #(.NUM_THREADS(T)) u_dut (
    .clk_i, .rst_ni, .mode_i, .ready_i, .stall_i, .long_stall_i,
    .tid_o, .valid_o, .switch_o
  );

  function automatic bit elig(int t);
    return ready_i[t] && !stall_i[t];
  endfunction

  // behavioural reference, evaluated on the inputs present at the edge
  task automatic model_edge();
    int found;
    found = -1;
    if (m_mode == 0) begin
      for (int k = 1; k <= T && found < 0; k++)
        if (elig((m_tid + k) % T)) found = (m_tid + k) % T;
      m_sw = 0;
      m_valid = (found >= 0);
      if (found >= 0) m_tid = found;
      m_mode = mode_i;
    end else if (long_stall_i || !ready_i[m_tid]) begin
      for (int k = 1; k < T && found < 0; k++)
        if (elig((m_tid + k) % T)) found = (m_tid + k) % T;
      if (found >= 0) begin
        m_tid = found; m_valid = 1; m_sw = 1; m_mode = mode_i;
      end else begin
        m_valid = 0; m_sw = 0;
      end
    end else begin
      m_valid = elig(m_tid); m_sw = 0;
    end
  endtask

  task automatic compare(string req);
    checks++;
    if (int'(tid_o) != m_tid || int'(valid_o) != m_valid || int'(switch_o) != m_sw) begin
      errors++;
      $display("FAIL %s: tid/valid/sw actual %0d/%0d/%0d expected %0d/%0d/%0d",
               req, tid_o, valid_o, switch_o, m_tid, m_valid, m_sw);
    end
  endtask

  task automatic step(input bit md, input logic [T-1:0] rdy, input logic [T-1:0] stl,
                      input bit ls, input string req);
    mode_i = md; ready_i = rdy; stall_i = stl; long_stall_i = ls;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(req);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");  // reset state while rst_ni low
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R2 fine rotation
    for (int i = 0; i < 5; i++) step(0, 4'b1111, 4'b0000, 0, "R2");
    // R3 skip stalled / not ready
    step(0, 4'b1111, 4'b0110, 0, "R3");
    step(0, 4'b0101, 4'b0000, 0, "R3");
    step(0, 4'b0101, 4'b0000, 0, "R3");
    // R4 nothing eligible
    step(0, 4'b0000, 4'b0000, 0, "R4");
    step(0, 4'b1111, 4'b1111, 0, "R4");
    // R11 long stall ignored in fine mode
    step(0, 4'b1111, 4'b0000, 1, "R11");
    step(0, 4'b1111, 4'b0000, 1, "R11");
    // R9 fine -> coarse applies after this boundary
    step(1, 4'b1111, 4'b0000, 0, "R9");
    // R5 hold and short stall
    for (int i = 0; i < 3; i++) step(1, 4'b1111, 4'b0000, 0, "R5");
    step(1, 4'b1111, 4'b1111, 0, "R5");
    step(1, 4'b1111, 4'b0000, 0, "R5");
    // R6 long stall switch
    step(1, 4'b1111, 4'b0000, 1, "R6");
    step(1, 4'b1111, 4'b0000, 0, "R6");
    step(1, 4'b1011, 4'b0001, 1, "R6");
    // R7 no other eligible thread
    step(1, 4'b1111, 4'b1111, 1, "R7");
    // R8 current thread loses ready
    step(1, 4'b0011, 4'b0000, 0, "R8");
    step(1, 4'b0011, 4'b0000, 0, "R8");
    // R9 coarse -> fine waits for a switch
    step(0, 4'b1111, 4'b0000, 0, "R9");
    step(0, 4'b1111, 4'b0000, 0, "R9");
    step(0, 4'b1111, 4'b0000, 1, "R9");
    step(0, 4'b1111, 4'b0000, 0, "R9");
    step(0, 4'b1111, 4'b0000, 0, "R10");
    // R12 mixed traffic, one-cycle latency against the model
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) < 3, T'($urandom | $urandom), T'($urandom & $urandom),
           ($urandom % 6) == 0, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule